// File: doc/BRIEF.md
# Three-Input Splittable Data ALU

This block is the data-path arithmetic and logic unit of a 32-bit image-processing signal processor. Each cycle it can take one operation on three 32-bit operands: a Boolean combination of all three chosen by an 8-bit truth-table code, an addition or subtraction that runs either as one 32-bit lane or as independent halfword or byte lanes, a low-order mask built from a bit count, or a lane mask expanded from a small per-lane flag register.

The second operand can be chosen at run time between two sources using the negative status flag. The whole write can also be made conditional on a signed less-than condition formed from the negative and overflow status flags. The register file, multiplier and decoder sit outside: operands, codes and flags arrive on ports, and the result and per-lane carry flags are registered outputs that keep their value whenever no write happens.

Top module: `dsp_data_unit`

## Requirements
- R1: With op_code 000 each result bit i equals tt_code[{opnd_a[i], B[i], opnd_c[i]}], where opnd_a supplies the most significant index bit and B is the selected second operand; carry_flags becomes 0.
- R2: With op_code 001 (add) or 010 (subtract, A + ~B + 1) and lane_sz 00 or 11, the result is the 32-bit sum or difference; carry_flags[0] is the carry out (1 on subtract when no borrow) and carry_flags[3:1] are 0.
- R3: With lane_sz 10 the add and subtract run as four independent byte lanes; no carry passes between bytes and carry_flags[k] is the carry out of byte k.
- R4: With lane_sz 01 the add and subtract run as two independent halfword lanes; carry_flags[1:0] hold the lane carries and carry_flags[3:2] are 0.
- R5: With op_code 011 the result has its n lowest bits set, n being B[7:0] unsigned; n = 0 gives 0 and n of 32 or more gives all ones; carry_flags becomes 0.
- R6: With op_code 100 each lane of the result is all ones when its flag in mf_in is 1 and zero otherwise: byte lanes use mf_in[3:0], halfword lanes mf_in[1:0], word uses mf_in[0]; carry_flags becomes 0.
- R7: B is opnd_b unless src_sel_en is 1, in which case B is opnd_b when neg_flag is 1 and opnd_c when neg_flag is 0.
- R8: When cond_en is 1 the write happens only if neg_flag XOR ovf_flag is 1 (signed less-than); otherwise result and carry_flags keep their values.
- R9: Outputs are 0 after reset; each accepted operation appears on the outputs one clock later; when op_valid is 0 or op_code is 101 to 111 the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select |
| tt_code | input | 8 | Truth table for the three-input Boolean function |
| lane_sz | input | 2 | Lane size: 00 word, 01 halfword, 10 byte, 11 word |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| opnd_c | input | 32 | Third operand, also alternate second operand |
| mf_in | input | 4 | Per-lane flags used by the expand operation |
| neg_flag | input | 1 | Negative status flag |
| ovf_flag | input | 1 | Overflow status flag |
| src_sel_en | input | 1 | Enables flag-driven choice of the second operand |
| cond_en | input | 1 | Makes the write depend on signed less-than |
| result | output | 32 | Registered result |
| carry_flags | output | 4 | Registered per-lane carry outs |

## Verification
The assertions watch, on every cycle, the holding behaviours (idle, unknown op codes, a failed condition), the constant-truth-table and mask boundary outputs, the upper carry flags in word mode and the word-wide expand. Whether each lane's sum is right, that carries stop at lane edges, that the truth-table index order is correct and that the second operand follows the negative flag can only be shown by the bench, which compares every cycle against a behavioural model over directed corner cases and a long run of mixed operations.

// File: rtl/ddu_pkg.sv
package ddu_pkg;
  typedef enum logic [2:0] {
    OP_BOOL   = 3'd0,
    OP_ADD    = 3'd1,
    OP_SUB    = 3'd2,
    OP_MASK   = 3'd3,
    OP_EXPAND = 3'd4
  } ddu_op_e;

  typedef enum logic [1:0] {
    LZ_WORD     = 2'b00,
    LZ_HALF     = 2'b01,
    LZ_BYTE     = 2'b10,
    LZ_WORD_ALT = 2'b11
  } ddu_lane_e;

  function automatic logic op_known(input logic [2:0] op);
    return op <= OP_EXPAND;
  endfunction
endpackage

// File: rtl/ddu_bool3.sv
module ddu_bool3 #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic [7:0]   table_code,
  output logic [W-1:0] bool_y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bool_y[i] = table_code[{in_a[i], in_b[i], in_c[i]}];
  end
endmodule

// File: rtl/ddu_lane_adder.sv
module ddu_lane_adder #(
  parameter int W  = 32,
  parameter int NL = 4
) (
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic          do_sub,
  input  logic [1:0]    lane_sz,
  output logic [W-1:0]  sum_y,
  output logic [NL-1:0] lane_carry
);
  import ddu_pkg::*;
  localparam int SL = W / NL;

  logic [NL-1:0] slice_cout;
  logic          is_byte;
  logic          is_half;

  assign is_byte = (lane_sz == LZ_BYTE);
  assign is_half = (lane_sz == LZ_HALF);

  for (genvar k = 0; k < NL; k++) begin : g_slice
    localparam bit EVEN = (k % 2) == 0;
    logic          starts_lane;
    logic          cin;
    logic [SL-1:0] b_x;
    logic [SL:0]   part;

    assign starts_lane = is_byte | (is_half & EVEN) | (k == 0);
    if (k == 0) begin : g_first
      assign cin = do_sub;
    end else begin : g_rest
      assign cin = starts_lane ? do_sub : slice_cout[k-1];
    end
    assign b_x  = in_b[k*SL +: SL] ^ {SL{do_sub}};
    assign part = {1'b0, in_a[k*SL +: SL]} + {1'b0, b_x} + {{SL{1'b0}}, cin};
    assign sum_y[k*SL +: SL] = part[SL-1:0];
    assign slice_cout[k]     = part[SL];
  end

  always_comb begin
    lane_carry = '0;
    if (is_byte) begin
      lane_carry = slice_cout;
    end else if (is_half) begin
      for (int j = 0; j < NL / 2; j++) lane_carry[j] = slice_cout[2*j+1];
    end else begin
      lane_carry[0] = slice_cout[NL-1];
    end
  end
endmodule

// File: rtl/ddu_mask_unit.sv
module ddu_mask_unit #(
  parameter int W  = 32,
  parameter int NL = 4
) (
  input  logic [7:0]    bit_count,
  input  logic [NL-1:0] lane_flags,
  input  logic [1:0]    lane_sz,
  output logic [W-1:0]  low_mask,
  output logic [W-1:0]  lane_mask
);
  import ddu_pkg::*;
  localparam int SL = W / NL;

  for (genvar i = 0; i < W; i++) begin : g_lowbit
    assign low_mask[i] = bit_count > 8'(i);
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic pick;
    always_comb begin
      case (lane_sz)
        LZ_BYTE: pick = lane_flags[k];
        LZ_HALF: pick = lane_flags[k/2];
        default: pick = lane_flags[0];
      endcase
    end
    assign lane_mask[k*SL +: SL] = {SL{pick}};
  end
endmodule

// File: rtl/dsp_data_unit.sv
module dsp_data_unit #(
  parameter int W  = 32,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [7:0]    tt_code,
  input  logic [1:0]    lane_sz,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [W-1:0]  opnd_c,
  input  logic [NL-1:0] mf_in,
  input  logic          neg_flag,
  input  logic          ovf_flag,
  input  logic          src_sel_en,
  input  logic          cond_en,
  output logic [W-1:0]  result,
  output logic [NL-1:0] carry_flags
);
  import ddu_pkg::*;

  logic [1:0]    rst_pipe;
  logic          rst_n_int;
  logic [W-1:0]  b_eff;
  logic          cond_ok;
  logic          wr_en;
  logic [W-1:0]  bool_y, sum_y, low_mask, lane_mask;
  logic [NL-1:0] lane_carry;
  logic [W-1:0]  res_d, res_q;
  logic [NL-1:0] flg_d, flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  assign b_eff   = (src_sel_en && !neg_flag) ? opnd_c : opnd_b;
  assign cond_ok = !cond_en || (neg_flag ^ ovf_flag);
  assign wr_en   = op_valid && op_known(op_code) && cond_ok;

  ddu_bool3 #(.W(W)) u_bool (
    .in_a(opnd_a), .in_b(b_eff), .in_c(opnd_c),
    .table_code(tt_code), .bool_y(bool_y)
  );

  ddu_lane_adder #(.W(W), .NL(NL)) u_add (
    .in_a(opnd_a), .in_b(b_eff), .do_sub(op_code == OP_SUB),
    .lane_sz(lane_sz), .sum_y(sum_y), .lane_carry(lane_carry)
  );

  ddu_mask_unit #(.W(W), .NL(NL)) u_mask (
    .bit_count(b_eff[7:0]), .lane_flags(mf_in), .lane_sz(lane_sz),
    .low_mask(low_mask), .lane_mask(lane_mask)
  );

  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    if (wr_en) begin
      flg_d = '0;
      case (op_code)
        OP_BOOL:         res_d = bool_y;
        OP_ADD, OP_SUB: begin
          res_d = sum_y;
          flg_d = lane_carry;
        end
        OP_MASK:         res_d = low_mask;
        default:         res_d = lane_mask;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (wr_en) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result      = res_q;
  assign carry_flags = flg_q;
endmodule

// File: rtl/ddu_checker.sv
module ddu_checker #(
  parameter int W  = 32,
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic [7:0]    tt_code,
  input logic [1:0]    lane_sz,
  input logic [W-1:0]  opnd_b,
  input logic [NL-1:0] mf_in,
  input logic          neg_flag,
  input logic          ovf_flag,
  input logic          src_sel_en,
  input logic          cond_en,
  input logic [W-1:0]  result,
  input logic [NL-1:0] carry_flags
);
  logic go;
  assign go = op_valid && !cond_en;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(carry_flags))); // R9

  AST_UNKNOWN_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 3'd4) |=> ($stable(result) && $stable(carry_flags))); // R9

  AST_COND_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_en && (neg_flag == ovf_flag)) |=> ($stable(result) && $stable(carry_flags))); // R8

  AST_TABLE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == 3'd0 && tt_code == 8'hFF) |=> (&result && carry_flags == '0)); // R1

  AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == 3'd3 && !src_sel_en && opnd_b[7:0] == 8'd0) |=> (result == '0)); // R5

  AST_MASK_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == 3'd3 && !src_sel_en && opnd_b[7:0] >= 8'(W)) |=> (&result)); // R5

  AST_WORD_UPPER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op_code == 3'd1 || op_code == 3'd2) && (lane_sz == 2'b00 || lane_sz == 2'b11))
    |=> (carry_flags[NL-1:1] == '0)); // R2

  AST_EXPAND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_code == 3'd4 && lane_sz == 2'b00) |=> (result == {W{$past(mf_in[0])}})); // R6
endmodule

bind dsp_data_unit ddu_checker #(.W(W), .NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .op_valid(op_valid), .op_code(op_code),
  .tt_code(tt_code), .lane_sz(lane_sz), .opnd_b(opnd_b), .mf_in(mf_in),
  .neg_flag(neg_flag), .ovf_flag(ovf_flag), .src_sel_en(src_sel_en),
  .cond_en(cond_en), .result(result), .carry_flags(carry_flags)
);

// File: tb/sim_dsp_data_unit.sv
module sim_dsp_data_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [7:0]  tt_code;
  logic [1:0]  lane_sz;
  logic [31:0] opnd_a, opnd_b, opnd_c;
  logic [3:0]  mf_in;
  logic        neg_flag, ovf_flag, src_sel_en, cond_en;
  logic [31:0] result;
  logic [3:0]  carry_flags;

  logic [31:0] exp_res;
  logic [3:0]  exp_flg;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  dsp_data_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .tt_code(tt_code), .lane_sz(lane_sz), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .opnd_c(opnd_c), .mf_in(mf_in), .neg_flag(neg_flag), .ovf_flag(ovf_flag),
    .src_sel_en(src_sel_en), .cond_en(cond_en), .result(result),
    .carry_flags(carry_flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Behavioural model of one clock: computes what the outputs become.
  task automatic model_step();
    logic [31:0] bb, r;
    logic [3:0]  f;
    int          lw, nl;
    longint unsigned m, av, bv, s;
    bit ok;
    bb = (src_sel_en && !neg_flag) ? opnd_c : opnd_b;
    ok = op_valid && (op_code <= 3'd4) && (!cond_en || (neg_flag != ovf_flag));
    lw = (lane_sz == 2'b10) ? 8 : (lane_sz == 2'b01) ? 16 : 32;
    nl = 32 / lw;
    m  = (64'd1 << lw) - 1;
    r = '0;
    f = '0;
    if (ok) begin
      case (op_code)
        3'd0: for (int i = 0; i < 32; i++) r[i] = tt_code[{opnd_a[i], bb[i], opnd_c[i]}];
        3'd1, 3'd2: for (int j = 0; j < nl; j++) begin
          av = (64'(opnd_a) >> (j*lw)) & m;
          bv = (64'(bb) >> (j*lw)) & m;
          if (op_code == 3'd2) s = av + ((~bv) & m) + 1;
          else                 s = av + bv;
          r = r | 32'((s & m) << (j*lw));
          f[j] = s[lw];
        end
        3'd3: r = (bb[7:0] >= 8'd32) ? 32'hFFFF_FFFF : 32'((64'd1 << bb[7:0]) - 1);
        default: for (int j = 0; j < nl; j++) if (mf_in[j]) r = r | 32'(m << (j*lw));
      endcase
      exp_res = r;
      exp_flg = f;
    end
  endtask

  task automatic run(input string tag, input bit v, input logic [2:0] op, input logic [7:0] tt,
                     input logic [1:0] lz, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] c, input logic [3:0] mf, input bit ng, input bit ov,
                     input bit ss, input bit ce);
    op_valid = v; op_code = op; tt_code = tt; lane_sz = lz;
    opnd_a = a; opnd_b = b; opnd_c = c; mf_in = mf;
    neg_flag = ng; ovf_flag = ov; src_sel_en = ss; cond_en = ce;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check({tag, " result"}, result, exp_res);
    check({tag, " flags"}, {28'd0, carry_flags}, {28'd0, exp_flg});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 0; op_code = 0; tt_code = 0; lane_sz = 0;
    opnd_a = 0; opnd_b = 0; opnd_c = 0; mf_in = 0;
    neg_flag = 0; ovf_flag = 0; src_sel_en = 0; cond_en = 0;
    exp_res = '0; exp_flg = '0;
    repeat (3) @(negedge clk);
    check("R9 reset result", result, 32'd0);
    check("R9 reset flags", {28'd0, carry_flags}, 32'd0);
    rst_n = 1'b1;
    repeat (3) run("R9 idle after reset", 0, 3'd0, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R1: majority, parity, A?B:C selector, constant
    run("R1 majority", 1, 3'd0, 8'hE8, 0, 32'hF0F0_1234, 32'hFF00_5678, 32'hCCCC_9ABC, 0, 0, 0, 0, 0);
    run("R1 parity",   1, 3'd0, 8'h96, 0, 32'hA5A5_0F0F, 32'h3C3C_FFFF, 32'h0000_1111, 0, 0, 0, 0, 0);
    run("R1 select",   1, 3'd0, 8'hCA, 0, 32'hFFFF_0000, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, 0, 0);
    run("R1 only A",   1, 3'd0, 8'hF0, 0, 32'h8000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    // R2: word arithmetic and the 11 alias
    run("R2 add carry",    1, 3'd1, 0, 2'b00, 32'hFFFF_FFFF, 32'h0000_0002, 0, 0, 0, 0, 0, 0);
    run("R2 add ripple",   1, 3'd1, 0, 2'b11, 32'h00FF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
    run("R2 sub noborrow", 1, 3'd2, 0, 2'b00, 32'h0000_0010, 32'h0000_0003, 0, 0, 0, 0, 0, 0);
    run("R2 sub borrow",   1, 3'd2, 0, 2'b00, 32'h0000_0001, 32'h0000_0002, 0, 0, 0, 0, 0, 0);
    // R3: byte lanes, carries must stop at byte edges
    run("R3 byte add",  1, 3'd1, 0, 2'b10, 32'hFF80_01FF, 32'h0180_FF01, 0, 0, 0, 0, 0, 0);
    run("R3 byte sub",  1, 3'd2, 0, 2'b10, 32'h0010_0500, 32'h0120_0501, 0, 0, 0, 0, 0, 0);
    // R4: halfword lanes
    run("R4 half add",  1, 3'd1, 0, 2'b01, 32'h0001_FFFF, 32'hFFFF_0001, 0, 0, 0, 0, 0, 0);
    run("R4 half sub",  1, 3'd2, 0, 2'b01, 32'h8000_0000, 32'h0001_0001, 0, 0, 0, 0, 0, 0);
    // R5: mask counts
    run("R5 mask 0",   1, 3'd3, 0, 0, 0, 32'd0,   0, 0, 0, 0, 0, 0);
    run("R5 mask 7",   1, 3'd3, 0, 0, 0, 32'd7,   0, 0, 0, 0, 0, 0);
    run("R5 mask 31",  1, 3'd3, 0, 0, 0, 32'd31,  0, 0, 0, 0, 0, 0);
    run("R5 mask 32",  1, 3'd3, 0, 0, 0, 32'd32,  0, 0, 0, 0, 0, 0);
    run("R5 mask 200", 1, 3'd3, 0, 0, 0, 32'hFF00_00C8, 0, 0, 0, 0, 0, 0);
    // R6: expand per lane size
    run("R6 expand byte", 1, 3'd4, 0, 2'b10, 0, 0, 0, 4'b0011, 0, 0, 0, 0);
    run("R6 expand byte alt", 1, 3'd4, 0, 2'b10, 0, 0, 0, 4'b1010, 0, 0, 0, 0);
    run("R6 expand half", 1, 3'd4, 0, 2'b01, 0, 0, 0, 4'b0110, 0, 0, 0, 0);
    run("R6 expand word", 1, 3'd4, 0, 2'b00, 0, 0, 0, 4'b1110, 0, 0, 0, 0);
    // R7: second operand follows the negative flag
    run("R7 neg1 picks b", 1, 3'd1, 0, 0, 32'd100, 32'd5, 32'd40, 0, 1, 1, 1, 0);
    run("R7 neg0 picks c", 1, 3'd1, 0, 0, 32'd100, 32'd5, 32'd40, 0, 0, 0, 1, 0);
    run("R7 mask via c",   1, 3'd3, 0, 0, 0, 32'd3, 32'd12, 0, 0, 0, 1, 0);
    // R8: conditional write
    run("R8 lt true",   1, 3'd3, 0, 0, 0, 32'd5, 0, 0, 1, 0, 0, 1);
    run("R8 lt false",  1, 3'd3, 0, 0, 0, 32'd9, 0, 0, 1, 1, 0, 1);
    run("R8 lt false2", 1, 3'd1, 0, 0, 32'd1, 32'd1, 0, 0, 0, 0, 0, 1);
    run("R8 lt via ovf", 1, 3'd3, 0, 0, 0, 32'd2, 0, 0, 0, 1, 0, 1);
    // R9: hold on idle and unknown op codes
    run("R9 bad op 5",  1, 3'd5, 8'hFF, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    run("R9 bad op 7",  1, 3'd7, 8'hFF, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    run("R9 idle",      0, 3'd0, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 600; k++) begin
      run("R1..R9 mixed", ($urandom % 8) != 0, 3'($urandom % 6), 8'($urandom),
          2'($urandom), $urandom, ($urandom % 4 == 0) ? 32'($urandom % 40) : $urandom,
          $urandom, 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          ($urandom % 4) == 0);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule